// File: doc/BRIEF.md
# Control Endpoint Handshake Flags

This block keeps the request flags for endpoint 0 of a USB function controller while it runs a control-read transfer. The packet engine reports events to it as one-cycle pulses: a SETUP packet arrived, an OUT data packet arrived (with its PID), an IN data packet was acknowledged by the host, and an OUT token started the status stage. From these the block sets three flags: OUT-ready, IN-ready and setup-seen. It raises a CPU interrupt for each flag whose enable is set.

Firmware reads and clears the flags through a small register port. Clearing works by writing zero, so a flag that hardware sets in the same cycle is not lost. The IN-ready flag comes out of reset already set. Firmware therefore starts an IN data stage just by enabling that interrupt.

The block also keeps the endpoint data toggle. It tells the packet engine which PID (DATA0 or DATA1) to generate for the next IN packet or to expect on the next OUT packet. Each stage boundary has its own toggle rule. While a setup is still unhandled, the block asks the engine to NAK IN tokens.

Top module: `ep0_handshake`

## Requirements
- R1: After reset, OUT-ready and setup-seen are 0, IN-ready is 1, both interrupt enables are 0, irq is 0, dataToggle is 0 (DATA0), inNak is 0 and pidErr is 0.
- R2: A setupRcvd pulse sets OUT-ready and setup-seen at the next clock edge.
- R3: An inAcked pulse sets IN-ready at the next clock edge.
- R4: A write to address 0 clears each flag whose data bit is 0 and leaves each flag whose bit is 1 unchanged. A write to address 1 loads the enables.
- R5: A hardware set of a flag in the same cycle as a software clear of that flag leaves the flag set.
- R6: irq equals, one cycle later, (OUT-ready AND OUT-enable) OR (IN-ready AND IN-enable). Enabling IN after reset therefore raises irq.
- R7: A setupRcvd pulse forces dataToggle to 1 (DATA1), whatever its previous value or the current stage.
- R8: Each inAcked pulse inverts dataToggle, so the IN packets of a data stage go DATA1, DATA0, DATA1, and so on.
- R9: The first outToken after a setup, while in the data stage, forces dataToggle to 1 for the status stage. Later outTokens have no effect on it.
- R10: An outRcvd whose PID bit (rxPidData1, 1 = DATA1) equals dataToggle sets OUT-ready and inverts dataToggle. A mismatching one leaves OUT-ready and dataToggle unchanged and pulses pidErr for one cycle.
- R11: inNak is 1 exactly while setup-seen is set.
- R12: Reading address 0 returns OUT-ready in bit 0, IN-ready in bit 1 and setup-seen in bit 2. Reading address 1 returns the OUT enable in bit 0 and the IN enable in bit 1. All other bits read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| setupRcvd | input | 1 | Pulse: SETUP packet received on endpoint 0 |
| outRcvd | input | 1 | Pulse: OUT data packet received on endpoint 0 |
| rxPidData1 | input | 1 | PID of the received OUT data packet, 1 = DATA1 |
| inAcked | input | 1 | Pulse: IN data packet acknowledged by the host |
| outToken | input | 1 | Pulse: OUT token addressed to endpoint 0 |
| cpuWe | input | 1 | CPU register write strobe |
| cpuAddr | input | ADDR_W | CPU register address (0 flags, 1 enables) |
| cpuWdata | input | REG_W | CPU write data |
| cpuRdata | output | REG_W | CPU read data for cpuAddr |
| irq | output | 1 | Registered CPU interrupt request |
| dataToggle | output | 1 | PID to use or expect next, 1 = DATA1 |
| inNak | output | 1 | Request to NAK IN tokens on endpoint 0 |
| pidErr | output | 1 | One-cycle pulse on an OUT PID mismatch |

## Verification
The assertions assume that each packet-engine event is a single-cycle pulse. They also assume that outRcvd, inAcked and outToken never arrive together, while setupRcvd may coincide with any of them and then wins. The PID check therefore excludes cycles with other events. The bench drives at most one engine event per cycle, apart from deliberate overlaps of an event with a software clear. It sweeps transfers with zero to four IN packets, with and without a bad OUT PID, and every combination of enables and flags.

// File: rtl/ep0_flags_pkg.sv
package ep0_flags_pkg;
  localparam int FLAG_N         = 3;
  localparam int FLAG_OUT_BIT   = 0;
  localparam int FLAG_IN_BIT    = 1;
  localparam int FLAG_SETUP_BIT = 2;
  localparam int EN_N           = 2;
  localparam int EN_OUT_BIT     = 0;
  localparam int EN_IN_BIT      = 1;

  typedef enum logic [1:0] {
    STG_IDLE   = 2'd0,
    STG_DATA   = 2'd1,
    STG_STATUS = 2'd2
  } stage_t;

  typedef struct packed {
    logic setOut;
    logic setIn;
    logic setSetup;
    logic togForce1;
    logic togFlip;
    logic pidBad;
  } ctlStrobe_t;
endpackage

// File: rtl/ep0_handshake_ctl.sv
module ep0_handshake_ctl
  import ep0_flags_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       setupRcvd,
  input  logic       outRcvd,
  input  logic       rxPidData1,
  input  logic       inAcked,
  input  logic       outToken,
  input  logic       curToggle,
  output ctlStrobe_t strobe
);
  stage_t stageQ, stageD;

  // Event decode; setup has priority over everything else.
  always_comb begin
    strobe = '0;
    stageD = stageQ;
    if (setupRcvd) begin
      strobe.setSetup  = 1'b1;
      strobe.setOut    = 1'b1;
      strobe.togForce1 = 1'b1;
      stageD           = STG_DATA;
    end else if (outRcvd) begin
      if (rxPidData1 == curToggle) begin
        strobe.setOut  = 1'b1;
        strobe.togFlip = 1'b1;
        if (stageQ == STG_STATUS) stageD = STG_IDLE;
      end else begin
        strobe.pidBad = 1'b1;
      end
    end else if (inAcked) begin
      strobe.setIn   = 1'b1;
      strobe.togFlip = 1'b1;
    end else if (outToken && stageQ == STG_DATA) begin
      strobe.togForce1 = 1'b1;
      stageD           = STG_STATUS;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) stageQ <= STG_IDLE;
    else       stageQ <= stageD;
  end
endmodule

// File: rtl/ep0_handshake_dp.sv
module ep0_handshake_dp
  import ep0_flags_pkg::*;
#(
  parameter int REG_W  = 8,
  parameter int ADDR_W = 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctlStrobe_t        strobe,
  input  logic              cpuWe,
  input  logic [ADDR_W-1:0] cpuAddr,
  input  logic [REG_W-1:0]  cpuWdata,
  output logic [REG_W-1:0]  cpuRdata,
  output logic              irq,
  output logic              dataToggle,
  output logic              pidErr,
  output logic              outReq,
  output logic              inReq,
  output logic              setupFlag,
  output logic              outIntEn,
  output logic              inIntEn
);
  localparam logic [ADDR_W-1:0] ADDR_FLAGS = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] ADDR_ENABLES = ADDR_W'(1);
  localparam logic [FLAG_N-1:0] FLAG_RST = FLAG_N'(1) << FLAG_IN_BIT;

  logic [FLAG_N-1:0] flagQ, hwSet, keepMask;
  logic [EN_N-1:0]   enQ;
  logic              unusedWdHi;

  assign unusedWdHi = ^cpuWdata[REG_W-1:FLAG_N];

  always_comb begin
    hwSet                 = '0;
    hwSet[FLAG_OUT_BIT]   = strobe.setOut;
    hwSet[FLAG_IN_BIT]    = strobe.setIn;
    hwSet[FLAG_SETUP_BIT] = strobe.setSetup;
    keepMask = (cpuWe && cpuAddr == ADDR_FLAGS) ? cpuWdata[FLAG_N-1:0] : '1;
  end

  // Write-zero-to-clear flags; a hardware set wins the same cycle.
  for (genvar i = 0; i < FLAG_N; i++) begin : g_flag
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) flagQ[i] <= FLAG_RST[i];
      else       flagQ[i] <= (flagQ[i] & keepMask[i]) | hwSet[i];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) enQ <= '0;
    else if (cpuWe && cpuAddr == ADDR_ENABLES) enQ <= cpuWdata[EN_N-1:0];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                 dataToggle <= 1'b0;
    else if (strobe.togForce1) dataToggle <= 1'b1;
    else if (strobe.togFlip)   dataToggle <= ~dataToggle;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      irq    <= 1'b0;
      pidErr <= 1'b0;
    end else begin
      irq    <= (flagQ[FLAG_OUT_BIT] & enQ[EN_OUT_BIT]) |
                (flagQ[FLAG_IN_BIT]  & enQ[EN_IN_BIT]);
      pidErr <= strobe.pidBad;
    end
  end

  always_comb begin
    cpuRdata = '0;
    if (cpuAddr == ADDR_FLAGS)        cpuRdata[FLAG_N-1:0] = flagQ;
    else if (cpuAddr == ADDR_ENABLES) cpuRdata[EN_N-1:0]   = enQ;
  end

  assign outReq    = flagQ[FLAG_OUT_BIT];
  assign inReq     = flagQ[FLAG_IN_BIT];
  assign setupFlag = flagQ[FLAG_SETUP_BIT];
  assign outIntEn  = enQ[EN_OUT_BIT];
  assign inIntEn   = enQ[EN_IN_BIT];
endmodule

// File: rtl/ep0_handshake.sv
module ep0_handshake
  import ep0_flags_pkg::*;
#(
  parameter int REG_W  = 8,
  parameter int ADDR_W = 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              setupRcvd,
  input  logic              outRcvd,
  input  logic              rxPidData1,
  input  logic              inAcked,
  input  logic              outToken,
  input  logic              cpuWe,
  input  logic [ADDR_W-1:0] cpuAddr,
  input  logic [REG_W-1:0]  cpuWdata,
  output logic [REG_W-1:0]  cpuRdata,
  output logic              irq,
  output logic              dataToggle,
  output logic              inNak,
  output logic              pidErr
);
  ctlStrobe_t strobe;
  logic outReq, inReq, setupFlag, outIntEn, inIntEn;

  ep0_handshake_ctl ctl_i (
    .clk(clk), .rstN(rstN), .setupRcvd(setupRcvd), .outRcvd(outRcvd),
    .rxPidData1(rxPidData1), .inAcked(inAcked), .outToken(outToken),
    .curToggle(dataToggle), .strobe(strobe)
  );

  ep0_handshake_dp #(.REG_W(REG_W), .ADDR_W(ADDR_W)) dp_i (
    .clk(clk), .rstN(rstN), .strobe(strobe), .cpuWe(cpuWe), .cpuAddr(cpuAddr),
    .cpuWdata(cpuWdata), .cpuRdata(cpuRdata), .irq(irq), .dataToggle(dataToggle),
    .pidErr(pidErr), .outReq(outReq), .inReq(inReq), .setupFlag(setupFlag),
    .outIntEn(outIntEn), .inIntEn(inIntEn)
  );

  // Unhandled setup: IN tokens get NAK.
  assign inNak = setupFlag;
endmodule

// File: rtl/ep0_handshake_chk.sv
module ep0_handshake_chk #(
  parameter int REG_W  = 8,
  parameter int ADDR_W = 1
) (
  input logic              clk,
  input logic              rstN,
  input logic              setupRcvd,
  input logic              outRcvd,
  input logic              rxPidData1,
  input logic              inAcked,
  input logic              outToken,
  input logic              cpuWe,
  input logic [ADDR_W-1:0] cpuAddr,
  input logic [REG_W-1:0]  cpuWdata,
  input logic              irq,
  input logic              dataToggle,
  input logic              pidErr,
  input logic              outReq,
  input logic              inReq,
  input logic              setupFlag,
  input logic              outIntEn,
  input logic              inIntEn
);
  // R2
  setup_sets_flags_chk: assert property (@(posedge clk) disable iff (!rstN)
    setupRcvd |=> (outReq && setupFlag));

  // R3
  in_ack_sets_flag_chk: assert property (@(posedge clk) disable iff (!rstN)
    inAcked |=> inReq);

  // R5
  set_beats_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    (inAcked && cpuWe && cpuAddr == ADDR_W'(0) && !cpuWdata[1]) |=> inReq);

  // R7
  setup_toggle_one_chk: assert property (@(posedge clk) disable iff (!rstN)
    setupRcvd |=> dataToggle);

  // R6
  irq_follows_flags_chk: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> (irq == $past((outReq && outIntEn) || (inReq && inIntEn))));

  // R10
  bad_pid_drop_chk: assert property (@(posedge clk) disable iff (!rstN)
    (outRcvd && !setupRcvd && !inAcked && !outToken && (rxPidData1 != dataToggle))
      |=> (pidErr && (dataToggle == $past(dataToggle))));
endmodule

bind ep0_handshake ep0_handshake_chk #(.REG_W(REG_W), .ADDR_W(ADDR_W)) chk_i (
  .clk(clk), .rstN(rstN), .setupRcvd(setupRcvd), .outRcvd(outRcvd),
  .rxPidData1(rxPidData1), .inAcked(inAcked), .outToken(outToken),
  .cpuWe(cpuWe), .cpuAddr(cpuAddr), .cpuWdata(cpuWdata), .irq(irq),
  .dataToggle(dataToggle), .pidErr(pidErr), .outReq(outReq), .inReq(inReq),
  .setupFlag(setupFlag), .outIntEn(outIntEn), .inIntEn(inIntEn)
);

// File: tb/ep0_handshake_tb_top.sv
`timescale 1ns/100ps
module ep0_handshake_tb_top;
  localparam int REG_W = 8;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic setupRcvd = 0, outRcvd = 0, rxPidData1 = 0, inAcked = 0, outToken = 0;
  logic cpuWe = 0;
  logic [0:0] cpuAddr = '0;
  logic [REG_W-1:0] cpuWdata = '0;
  logic [REG_W-1:0] cpuRdata;
  logic irq, dataToggle, inNak, pidErr;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  // Bench model of the requirements
  logic mOut, mIn, mSet, mOutEn, mInEn, mTog, mIrq, mPe;
  int   mStage; // 0 idle, 1 data, 2 status

  always #2 clk = ~clk;

  ep0_handshake #(.REG_W(REG_W), .ADDR_W(1)) dut_i (
    .clk(clk), .rstN(rstN), .setupRcvd(setupRcvd), .outRcvd(outRcvd),
    .rxPidData1(rxPidData1), .inAcked(inAcked), .outToken(outToken),
    .cpuWe(cpuWe), .cpuAddr(cpuAddr), .cpuWdata(cpuWdata), .cpuRdata(cpuRdata),
    .irq(irq), .dataToggle(dataToggle), .inNak(inNak), .pidErr(pidErr)
  );

  task automatic chk(input logic [REG_W-1:0] act, input logic [REG_W-1:0] exp,
                     input string tag, input string what);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  // Compare all outputs against the model; called just after a negedge.
  task automatic compareAll(input string tag);
    logic [REG_W-1:0] rdF, rdE;
    cpuAddr = 1'b0;
    #0.2 rdF = cpuRdata;
    cpuAddr = 1'b1;
    #0.2 rdE = cpuRdata;
    cpuAddr = 1'b0;
    chk(rdF, REG_W'({mSet, mIn, mOut}), tag, "flags R12");
    chk(rdE, REG_W'({mInEn, mOutEn}), tag, "enables R12");
    chk(REG_W'(irq), REG_W'(mIrq), tag, "irq R6");
    chk(REG_W'(dataToggle), REG_W'(mTog), tag, "toggle");
    chk(REG_W'(inNak), REG_W'(mSet), tag, "inNak R11");
    chk(REG_W'(pidErr), REG_W'(mPe), tag, "pidErr");
  endtask

  // One clock with the given stimulus; assumes it is entered at a negedge.
  task automatic cyc(input logic su, input logic ou, input logic pd, input logic ia,
                     input logic ot, input logic we, input logic ad,
                     input logic [REG_W-1:0] wd, input string tag);
    logic sOut, sIn, sSet, pe, nIrq;
    setupRcvd = su; outRcvd = ou; rxPidData1 = pd; inAcked = ia; outToken = ot;
    cpuWe = we; cpuAddr = ad; cpuWdata = wd;
    @(posedge clk);
    nIrq = (mOut & mOutEn) | (mIn & mInEn);
    sOut = 0; sIn = 0; sSet = 0; pe = 0;
    if (su) begin
      sSet = 1; sOut = 1; mTog = 1; mStage = 1;
    end else if (ou) begin
      if (pd == mTog) begin
        sOut = 1; mTog = ~mTog;
        if (mStage == 2) mStage = 0;
      end else pe = 1;
    end else if (ia) begin
      sIn = 1; mTog = ~mTog;
    end else if (ot && mStage == 1) begin
      mTog = 1; mStage = 2;
    end
    if (we && ad == 1'b0) begin
      mOut = mOut & wd[0]; mIn = mIn & wd[1]; mSet = mSet & wd[2];
    end
    mOut = mOut | sOut; mIn = mIn | sIn; mSet = mSet | sSet;
    if (we && ad == 1'b1) begin
      mOutEn = wd[0]; mInEn = wd[1];
    end
    mIrq = nIrq; mPe = pe;
    @(negedge clk);
    setupRcvd = 0; outRcvd = 0; rxPidData1 = 0; inAcked = 0; outToken = 0;
    cpuWe = 0; cpuWdata = '0;
    compareAll(tag);
  endtask

  task automatic idle(input string tag);
    cyc(0, 0, 0, 0, 0, 0, 0, '0, tag);
  endtask

  task automatic finish();
    if (!finished) begin
      finished = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #800000;
    errors++;
    checks++;
    $display("FAIL watchdog expired");
    finish();
  end

  initial begin
    mOut = 0; mIn = 1; mSet = 0; mOutEn = 0; mInEn = 0; mTog = 0;
    mIrq = 0; mPe = 0; mStage = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    compareAll("R1");
    idle("R1");

    // R6: IN interrupt appears as soon as it is enabled (flag starts set)
    cyc(0, 0, 0, 0, 0, 1, 1, 8'b10, "R4");
    idle("R6");
    chk(REG_W'(irq), REG_W'(1), "R6", "irq after IN enable");
    // R4: clear IN flag with a zero bit, others written 1
    cyc(0, 0, 0, 0, 0, 1, 0, 8'b101, "R4");
    idle("R6");
    chk(REG_W'(irq), REG_W'(0), "R6", "irq after IN clear");

    // Full control-read transfers with 0..4 IN packets
    for (int n = 0; n <= 4; n++) begin
      for (int bad = 0; bad < 2; bad++) begin
        cyc(1, 0, 0, 0, 0, 0, 0, '0, "R2");
        chk(REG_W'(dataToggle), REG_W'(1), "R7", "toggle after setup");
        chk(REG_W'(inNak), REG_W'(1), "R11", "NAK while setup pending");
        cyc(0, 0, 0, 0, 0, 1, 0, 8'b010, "R4");
        chk(REG_W'(inNak), REG_W'(0), "R11", "NAK released");
        for (int k = 0; k < n; k++) begin
          cyc(0, 0, 0, 1, 0, 0, 0, '0, "R3/R8");
          chk(REG_W'(dataToggle), REG_W'(((k + 1) % 2) == 0), "R8", "IN toggle sequence");
        end
        cyc(0, 0, 0, 0, 1, 0, 0, '0, "R9");
        chk(REG_W'(dataToggle), REG_W'(1), "R9", "status stage DATA1");
        cyc(0, 0, 0, 0, 1, 0, 0, '0, "R9");
        if (bad != 0) begin
          cyc(0, 1, 0, 0, 0, 0, 0, '0, "R10");
          chk(REG_W'(pidErr), REG_W'(1), "R10", "pid mismatch pulse");
        end
        cyc(0, 1, 1, 0, 0, 0, 0, '0, "R10");
        chk(REG_W'(dataToggle), REG_W'(0), "R10", "toggle after status");
        cyc(0, 0, 0, 0, 0, 1, 0, 8'b000, "R4");
      end
    end

    // R7: setup in the middle of a data stage restarts the toggle
    cyc(1, 0, 0, 0, 0, 0, 0, '0, "R7");
    cyc(0, 0, 0, 1, 0, 0, 0, '0, "R8");
    cyc(1, 0, 0, 0, 0, 0, 0, '0, "R7");
    chk(REG_W'(dataToggle), REG_W'(1), "R7", "toggle forced again");

    // R5: hardware set colliding with a software clear of all flags
    cyc(1, 0, 0, 0, 0, 1, 0, 8'b000, "R5");
    cyc(0, 0, 0, 1, 0, 1, 0, 8'b000, "R5");
    cyc(0, 1, 0, 0, 0, 1, 0, 8'b000, "R5");
    cyc(0, 1, 1, 0, 0, 1, 0, 8'b000, "R5");
    cyc(0, 0, 0, 0, 0, 1, 0, 8'b000, "R4");

    // R6: every enable combination against every OUT/IN flag combination
    for (int e = 0; e < 4; e++) begin
      for (int f = 0; f < 4; f++) begin
        cyc(0, 0, 0, 0, 0, 1, 0, 8'b000, "R4");
        if (f[0]) cyc(1, 0, 0, 0, 0, 0, 0, '0, "R2");
        if (f[1]) cyc(0, 0, 0, 1, 0, 0, 0, '0, "R3");
        cyc(0, 0, 0, 0, 0, 1, 1, REG_W'(e), "R12");
        idle("R6");
        idle("R6");
      end
    end

    finish();
  end
endmodule